// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox

This block is a bank of doorbell channels. Any bus master can use it to signal a target core and to leave a record of who signalled. Each channel keeps one vector of source flags. Two register views reach that vector: a raise view and an acknowledge view.

Writing ones through the raise view sets flags. A separate trigger bit in the raise view fires a one-cycle interrupt pulse toward the channel's core. Writing ones through the acknowledge view clears flags. Both views read back the same flag vector.

The register port is plain and word-addressed: address, write enable, 32-bit write data and 32-bit combinational read data. Each channel has one interrupt output. Software decides what each flag means.

Top module: `ipc_mbox`

## Requirements
- R1: After synchronous reset every flag is 0, every register reads 0 and no interrupt output is high.
- R2: A write to the raise register of channel c (word offset c, c in 0..5) sets flag n of that channel for every write-data bit n+4 that is 1. Flags written as 0 keep their value. The new value is readable from the next cycle.
- R3: A write to the acknowledge register of channel c (word offset 8+c) clears flag n for every write-data bit n+4 that is 1. Flags written as 0 keep their value.
- R4: Both registers of a channel read the channel's 28 flags in bits 31:4, with flag n at bit n+4. Bits 3:0 read 0 in both views, including the trigger bit and the reserved bits 3:1 of the raise view.
- R5: A raise-register write with bit 0 set drives that channel's interrupt output high for exactly the one cycle after the write. The trigger bit is not stored, and a write with bit 0 clear produces no pulse.
- R6: Channels are independent: a write to one channel changes no other channel's flags or interrupt output.
- R7: Offsets 6, 7, 14 and 15 are unmapped. Reads there return 0, and writes there change no flag and raise no interrupt.
- R8: Bit 0 of the acknowledge register is reserved. Writing 1 there produces no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Word offset of the accessed register |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_pulse | output | 6 | Per-channel interrupt pulse |

## Verification
The bench builds the block with its default parameters: six channels of 28 flags on a 4-bit word address. With that configuration the whole address space is small enough to read after every write. For every channel and every flag, the bench sets the flag and clears it again through single-bit writes, and after each write it reads all sixteen offsets. Any leakage between channels, between the two views or into the unmapped holes is therefore seen at once. Trigger writes and writes to reserved bits go to each channel to check the pulse timing and that the pulse lasts one cycle.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

    localparam int NUM_CH   = 6;
    localparam int NUM_SRC  = 28;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 32;
    localparam int ACK_BASE = 8;
    localparam int FLAG_LSB = DATA_W - NUM_SRC;
    localparam int CH_W     = $clog2(NUM_CH);
    localparam int TRIG_BIT = 0;

    typedef logic [NUM_SRC-1:0] flags_t;

    typedef enum logic [1:0] {
        VIEW_NONE  = 2'd0,
        VIEW_RAISE = 2'd1,
        VIEW_ACK   = 2'd2
    } view_e;

    typedef struct packed {
        view_e           view;
        logic [CH_W-1:0] ch;
    } dec_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.view = VIEW_NONE;
        d.ch   = '0;
        if (a < ADDR_W'(NUM_CH)) begin
            d.view = VIEW_RAISE;
            d.ch   = CH_W'(a);
        end else if (a >= ADDR_W'(ACK_BASE) && a < ADDR_W'(ACK_BASE + NUM_CH)) begin
            d.view = VIEW_ACK;
            d.ch   = CH_W'(a - ADDR_W'(ACK_BASE));
        end
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] pack_flags(input flags_t f);
        return {f, {FLAG_LSB{1'b0}}};
    endfunction

endpackage

// File: rtl/ipc_mbox_decode.sv
module ipc_mbox_decode
    import ipc_mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output logic [NUM_CH-1:0] set_we,
    output logic [NUM_CH-1:0] clr_we,
    output logic              rd_hit,
    output logic [CH_W-1:0]   rd_ch
);

    dec_t dec;

    always_comb begin
        dec = decode(addr);
        rd_hit = (dec.view != VIEW_NONE);
        rd_ch  = dec.ch;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_strobe
        always_comb begin
            set_we[c] = wr_en && dec.view == VIEW_RAISE && dec.ch == CH_W'(c);
            clr_we[c] = wr_en && dec.view == VIEW_ACK   && dec.ch == CH_W'(c);
        end
    end

    // R6: one port, so at most one channel strobe per cycle
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({set_we, clr_we}));

    // R7: an unmapped write reaches no channel
    a_r7_hole_no_strobe: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_hit) |-> (set_we == '0 && clr_we == '0));

endmodule

// File: rtl/ipc_mbox_channel.sv
module ipc_mbox_channel
    import ipc_mbox_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   set_we,
    input  logic   clr_we,
    input  logic   trig,
    input  flags_t wr_bits,
    output flags_t flags,
    output logic   irq
);

    flags_t set_mask;
    flags_t clr_mask;
    flags_t flags_nxt;

    always_comb begin
        set_mask  = set_we ? wr_bits : '0;
        clr_mask  = clr_we ? wr_bits : '0;
        // a set beats a clear of the same flag
        flags_nxt = (flags & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            irq   <= 1'b0;
        end else begin
            flags <= flags_nxt;
            irq   <= trig && set_we;
        end
    end

    // R2: ones written through the raise view are set next cycle
    a_r2_set_lands: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((flags & $past(wr_bits)) == $past(wr_bits)));

    // R3: ones written through the acknowledge view are cleared next cycle
    a_r3_clear_lands: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !set_we) |=> ((flags & $past(wr_bits)) == '0));

    // R2, R3: flags do not move without a write to this channel
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!set_we && !clr_we) |=> $stable(flags));

    // R5: a trigger write pulses the interrupt in the next cycle
    a_r5_pulse_follows: assert property (@(posedge clk) disable iff (rst)
        (set_we && trig) |=> irq);

    // R5, R8: no pulse without a raise-view trigger write
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !(set_we && trig) |=> !irq);

endmodule

// File: rtl/ipc_mbox.sv
module ipc_mbox
    import ipc_mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0] irq_pulse
);

    logic [NUM_CH-1:0]         set_we;
    logic [NUM_CH-1:0]         clr_we;
    logic                      rd_hit;
    logic [CH_W-1:0]           rd_ch;
    flags_t                    ch_flags [NUM_CH];
    logic [NUM_CH*NUM_SRC-1:0] flags_flat;
    flags_t                    wr_bits;
    logic                      wr_trig;

    assign wr_bits = reg_wdata[DATA_W-1:FLAG_LSB];
    assign wr_trig = reg_wdata[TRIG_BIT];

    ipc_mbox_decode u_decode (
        .clk    (clk),
        .rst    (rst),
        .addr   (reg_addr),
        .wr_en  (reg_wr_en),
        .set_we (set_we),
        .clr_we (clr_we),
        .rd_hit (rd_hit),
        .rd_ch  (rd_ch)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ipc_mbox_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .set_we  (set_we[c]),
            .clr_we  (clr_we[c]),
            .trig    (wr_trig),
            .wr_bits (wr_bits),
            .flags   (ch_flags[c]),
            .irq     (irq_pulse[c])
        );
        assign flags_flat[c*NUM_SRC +: NUM_SRC] = ch_flags[c];
    end

    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_hit && rd_ch == CH_W'(c))
                reg_rdata = pack_flags(ch_flags[c]);
        end
    end

    // R4: the low nibble of any read is zero
    a_r4_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[FLAG_LSB-1:0] == '0);

    // R7: unmapped offsets read zero
    a_r7_hole_reads_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_hit |-> reg_rdata == '0);

    // R7: unmapped writes leave every flag alone
    a_r7_hole_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && !rd_hit) |=> $stable(flags_flat));

    // R6: at most one channel pulses per cycle
    a_r6_one_irq: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_pulse));

endmodule

// File: tb/ipc_mbox_tb_top.sv
module ipc_mbox_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  reg_addr;
    logic        reg_wr_en;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [5:0]  irq_pulse;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [27:0] m [6];

    always #5 clk = ~clk;

    ipc_mbox dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_pulse (irq_pulse)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input int a);
        if (a < 6) return {m[a], 4'b0};
        if (a >= 8 && a < 14) return {m[a-8], 4'b0};
        return 32'h0;
    endfunction

    task automatic read_all(input string tag);
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            reg_addr = 4'(a);
            #1;
            check(tag, reg_rdata, model_read(a));
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d, input string tag);
        logic [5:0] exp_irq;
        exp_irq = '0;
        if (a < 6) begin
            m[a] = m[a] | d[31:4];
            if (d[0]) exp_irq[a] = 1'b1;
        end else if (a >= 8 && a < 14) begin
            m[a-8] = m[a-8] & ~d[31:4];
        end
        @(negedge clk);
        reg_addr  = 4'(a);
        reg_wdata = d;
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_wdata = '0;
        check({tag, " irq"}, 32'(irq_pulse), 32'(exp_irq));
        @(negedge clk);
        check("R5 pulse one cycle", 32'(irq_pulse), 32'h0);
    endtask

    initial begin
        for (int c = 0; c < 6; c++) m[c] = '0;
        rst = 1'b1;
        reg_addr = '0;
        reg_wr_en = 1'b0;
        reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 irq after reset", 32'(irq_pulse), 32'h0);
        read_all("R1 reset read");

        // R2, R3, R4: walk every flag of every channel
        for (int c = 0; c < 6; c++) begin
            for (int b = 0; b < 28; b++) begin
                wr(c, 32'h1 << (b + 4), "R2 single set");
                read_all("R2 R4 set visible in both views");
                wr(c + 8, 32'h1 << (b + 4), "R3 single clear");
                read_all("R3 clear visible in both views");
            end
        end

        // R2, R3, R6: patterns, zero writes and partial clears per channel
        for (int c = 0; c < 6; c++) begin
            wr(c, 32'hA5A5_A5A0 ^ (32'(c) << 8), "R2 pattern set");
            wr(c, 32'h0, "R2 zero write");
            wr(c + 8, 32'h0, "R3 zero write");
            read_all("R6 pattern independence");
        end
        for (int c = 0; c < 6; c++) begin
            wr(c + 8, 32'h0F0F_0F00, "R3 partial clear");
            wr(c, 32'h0000_F000, "R2 add bits");
            read_all("R3 partial clear result");
        end

        // R5, R4, R8: triggers and reserved bits
        for (int c = 0; c < 6; c++) begin
            wr(c, 32'h0000_0001, "R5 trigger");
            wr(c, 32'h0000_000E, "R4 reserved raise bits");
            wr(c + 8, 32'h0000_000F, "R8 ack bit0");
            read_all("R4 R5 trigger not stored");
        end
        wr(3, 32'h8000_0011, "R5 trigger with set");
        read_all("R5 R2 combined write");

        // R7: unmapped holes
        wr(6,  32'hFFFF_FFFF, "R7 hole 6");
        wr(7,  32'hFFFF_FFFF, "R7 hole 7");
        wr(14, 32'hFFFF_FFFF, "R7 hole 14");
        wr(15, 32'hFFFF_FFFF, "R7 hole 15");
        read_all("R7 holes ignored");

        // R3: clear everything
        for (int c = 0; c < 6; c++) wr(c + 8, 32'hFFFF_FFF0, "R3 full clear");
        read_all("R3 all cleared");

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule